// File: doc/BRIEF.md
# Wormhole Mesh Node Traffic Controller

This block steers worms through one node of a mesh network. A worm is a header flit followed by zero or more body flits; the final flit carries a tail flag. The node has four neighbour links and one local link to a processing element or memory. The header holds the destination coordinates. The controller picks a minimal dimension-ordered route and reserves the chosen output for the whole worm. Body flits then follow that path with no routing information of their own.

Each input uses valid/ready flow control, and so does each output link. When several inputs want the same free output in one cycle, a per-output round-robin arbiter picks one winner. The losers are held back by deasserting ready, and no flit is lost.

Every 32-bit output link can run in one of three widths: full width, two 16-bit sub-channels, or four 8-bit sub-channels. In the narrower settings each flit is sent over several beats, least significant slice first. A sampler keeps a registered busy bit for every output. From those bits the block reports how many neighbour links are free, and how many sub-channels that amounts to in the current width setting.

Top module: `worm_node_ctrl`

## Requirements
- R1: During and right after reset, every output valid is low, every input ready is low, every busy bit is low, and the free link count equals 4.
- R2: The header carries the destination X in bits [7:4] and Y in bits [3:0]. If destination X is above the node X the worm leaves on port 0; if it is below, on port 1. When the X values match, Y above goes to port 2 and Y below to port 3. A worm whose X and Y both match goes to port 4, the local port. X is always resolved before Y.
- R3: An output stays reserved from the header grant until the tail flit has been accepted from the owning input. While it is reserved, any other input routed to that output sees ready low.
- R4: Every flit of a worm appears on the chosen output in order, exactly once, with its tail flag intact, under any pattern of output backpressure. While an output is valid and not ready, its data and tail flag hold.
- R5: When several inputs request one free output in the same cycle, the grant goes to the first requester in index order after the input granted last on that output. After reset the search starts at input 0.
- R6: chanMode 00 sends a flit in one beat. chanMode 01 sends it in two beats of 16 bits on outData[15:0], low half first, with the upper bits zero. chanMode 10 or 11 sends it in four beats of 8 bits on outData[7:0], lowest byte first. outLast is high only on the final beat of the tail flit.
- R7: Each busy bit is a registered sample of "reserved or holding a flit". It rises one cycle after the header grant, which is the cycle after input ready first goes high. It returns to 0 once the tail's last beat has left.
- R8: freeLinks counts the neighbour ports 0 to 3 whose busy bit is low. freeSubCh equals freeLinks times 1, 2 or 4, for chanMode 00, 01 or 1x respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nodeX | input | 4 | X coordinate of this node |
| nodeY | input | 4 | Y coordinate of this node |
| chanMode | input | 2 | Link width setting: 00 full, 01 halves, 1x quarters |
| inValid | input | 5 | Flit valid per input port |
| inData | input | 5x32 | Flit per input port |
| inLast | input | 5 | Tail flag per input port |
| inReady | output | 5 | Flit accepted per input port |
| outValid | output | 5 | Beat valid per output port |
| outData | output | 5x32 | Beat data per output port |
| outLast | output | 5 | Final beat of the tail flit |
| outReady | input | 5 | Downstream accepts the beat |
| chanBusy | output | 5 | Sampled busy bit per output |
| freeLinks | output | 3 | Number of idle neighbour links |
| freeSubCh | output | 5 | Number of idle sub-channels on neighbour links |

## Verification
Two things can happen on the same output in the same cycle. The tail of one worm releases the reservation while a second worm's header is waiting for the grant. Separately, the last beat of a held flit drains while the next flit loads. The bench provokes both by forking two worms from different inputs to one output, in both the full and the serialized widths, with random output backpressure. A scoreboard fed at each input handshake judges the outcome: any flit that is lost, duplicated or interleaved between the two worms shows up as a mismatch or as a leftover queue entry. The order in which the headers were accepted is compared with the round-robin rule.

// File: rtl/wnc_pkg.sv
package wnc_pkg;
  localparam int NUM_PORTS = 5;
  localparam int NET_PORTS = 4;
  localparam int IDX_W = $clog2(NUM_PORTS);

  typedef logic [IDX_W-1:0] portIdx_t;

  localparam portIdx_t PORT_XP = 3'd0;
  localparam portIdx_t PORT_XN = 3'd1;
  localparam portIdx_t PORT_YP = 3'd2;
  localparam portIdx_t PORT_YN = 3'd3;
  localparam portIdx_t PORT_LOC = 3'd4;

  typedef struct packed {
    logic [NUM_PORTS-1:0] load;
    portIdx_t [NUM_PORTS-1:0] loadSrc;
  } dpCtl_t;
endpackage

// File: rtl/worm_node_ctl.sv
module worm_node_ctl
  import wnc_pkg::*;
#(
  parameter int COORD_W = 4,
  localparam int HDR_W = 2 * COORD_W
) (
  input  logic clk,
  input  logic rst,
  input  logic [COORD_W-1:0] nodeX,
  input  logic [COORD_W-1:0] nodeY,
  input  logic [1:0] chanMode,
  input  logic [NUM_PORTS-1:0] inValid,
  input  logic [NUM_PORTS-1:0] inLast,
  input  logic [NUM_PORTS-1:0][HDR_W-1:0] inHdr,
  input  logic [NUM_PORTS-1:0] canLoad,
  input  logic [NUM_PORTS-1:0] outValidQ,
  output logic [NUM_PORTS-1:0] inReady,
  output dpCtl_t strobe,
  output logic [NUM_PORTS-1:0] reservedQ,
  output logic [NUM_PORTS-1:0] chanBusy,
  output logic [2:0] freeLinks,
  output logic [4:0] freeSubCh
);

  logic [NUM_PORTS-1:0] grantedQ;
  portIdx_t [NUM_PORTS-1:0] grantOut;
  portIdx_t [NUM_PORTS-1:0] ownerQ;
  portIdx_t [NUM_PORTS-1:0] rrPtr;
  portIdx_t [NUM_PORTS-1:0] reqPort;
  logic [NUM_PORTS-1:0][NUM_PORTS-1:0] reqMat;
  logic [NUM_PORTS-1:0] gntValid;
  portIdx_t [NUM_PORTS-1:0] gntIdx;

  // Minimal dimension-ordered route: settle X first, then Y, then deliver.
  function automatic portIdx_t routeOf(input logic [HDR_W-1:0] hdr,
                                       input logic [COORD_W-1:0] hereX,
                                       input logic [COORD_W-1:0] hereY);
    logic [COORD_W-1:0] dstX;
    logic [COORD_W-1:0] dstY;
    dstX = hdr[HDR_W-1:COORD_W];
    dstY = hdr[COORD_W-1:0];
    if (dstX > hereX) return PORT_XP;
    if (dstX < hereX) return PORT_XN;
    if (dstY > hereY) return PORT_YP;
    if (dstY < hereY) return PORT_YN;
    return PORT_LOC;
  endfunction

  always_comb begin
    for (int i = 0; i < NUM_PORTS; i++) begin
      reqPort[i] = routeOf(inHdr[i], nodeX, nodeY);
      for (int o = 0; o < NUM_PORTS; o++) begin
        reqMat[i][o] = inValid[i] && !grantedQ[i] && (reqPort[i] == portIdx_t'(o));
      end
    end
  end

  // Round-robin search per output, starting just after the last winner.
  always_comb begin
    int cand;
    for (int o = 0; o < NUM_PORTS; o++) begin
      gntValid[o] = 1'b0;
      gntIdx[o] = '0;
      for (int k = 1; k <= NUM_PORTS; k++) begin
        cand = int'(rrPtr[o]) + k;
        if (cand >= NUM_PORTS) cand = cand - NUM_PORTS;
        if (!reservedQ[o] && !gntValid[o] && reqMat[cand][o]) begin
          gntValid[o] = 1'b1;
          gntIdx[o] = portIdx_t'(cand);
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_PORTS; i++) begin
      inReady[i] = grantedQ[i] && canLoad[grantOut[i]];
    end
    for (int o = 0; o < NUM_PORTS; o++) begin
      strobe.load[o] = reservedQ[o] && inValid[ownerQ[o]] && inReady[ownerQ[o]];
      strobe.loadSrc[o] = ownerQ[o];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reservedQ <= '0;
      grantedQ <= '0;
      chanBusy <= '0;
      for (int o = 0; o < NUM_PORTS; o++) begin
        rrPtr[o] <= portIdx_t'(NUM_PORTS - 1);
        ownerQ[o] <= '0;
        grantOut[o] <= '0;
      end
    end else begin
      chanBusy <= reservedQ | outValidQ;
      for (int o = 0; o < NUM_PORTS; o++) begin
        if (gntValid[o]) begin
          reservedQ[o] <= 1'b1;
          ownerQ[o] <= gntIdx[o];
          rrPtr[o] <= gntIdx[o];
          grantedQ[gntIdx[o]] <= 1'b1;
          grantOut[gntIdx[o]] <= portIdx_t'(o);
        end else if (strobe.load[o] && inLast[ownerQ[o]]) begin
          reservedQ[o] <= 1'b0;
          grantedQ[ownerQ[o]] <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    freeLinks = 3'd0;
    for (int o = 0; o < NET_PORTS; o++) begin
      if (!chanBusy[o]) freeLinks = freeLinks + 3'd1;
    end
    case (chanMode)
      2'b00:   freeSubCh = {2'b00, freeLinks};
      2'b01:   freeSubCh = {1'b0, freeLinks, 1'b0};
      default: freeSubCh = {freeLinks, 2'b00};
    endcase
  end

endmodule

// File: rtl/worm_node_dp.sv
module worm_node_dp
  import wnc_pkg::*;
#(
  parameter int FLIT_W = 32,
  localparam int HALF = FLIT_W / 2,
  localparam int QTR = FLIT_W / 4
) (
  input  logic clk,
  input  logic rst,
  input  logic [1:0] chanMode,
  input  dpCtl_t strobe,
  input  logic [NUM_PORTS-1:0][FLIT_W-1:0] inData,
  input  logic [NUM_PORTS-1:0] inLast,
  input  logic [NUM_PORTS-1:0] outReady,
  output logic [NUM_PORTS-1:0] canLoad,
  output logic [NUM_PORTS-1:0] outValid,
  output logic [NUM_PORTS-1:0][FLIT_W-1:0] outData,
  output logic [NUM_PORTS-1:0] outLast
);

  logic [1:0] lastBeatIdx;

  always_comb begin
    case (chanMode)
      2'b00:   lastBeatIdx = 2'd0;
      2'b01:   lastBeatIdx = 2'd1;
      default: lastBeatIdx = 2'd3;
    endcase
  end

  for (genvar o = 0; o < NUM_PORTS; o++) begin : g_out
    logic [FLIT_W-1:0] flitQ;
    logic lastQ;
    logic validQ;
    logic [1:0] beatQ;
    logic finalBeat;
    logic [HALF-1:0] halfSel;
    logic [QTR-1:0] qtrSel;
    logic [FLIT_W-1:0] beatData;

    assign finalBeat = (beatQ == lastBeatIdx);
    assign canLoad[o] = !validQ || (outReady[o] && finalBeat);
    assign halfSel = flitQ[int'(beatQ[0]) * HALF +: HALF];
    assign qtrSel = flitQ[int'(beatQ) * QTR +: QTR];

    always_comb begin
      case (chanMode)
        2'b00:   beatData = flitQ;
        2'b01:   beatData = {{(FLIT_W - HALF){1'b0}}, halfSel};
        default: beatData = {{(FLIT_W - QTR){1'b0}}, qtrSel};
      endcase
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        flitQ <= '0;
        lastQ <= 1'b0;
        validQ <= 1'b0;
        beatQ <= 2'd0;
      end else if (strobe.load[o]) begin
        flitQ <= inData[strobe.loadSrc[o]];
        lastQ <= inLast[strobe.loadSrc[o]];
        validQ <= 1'b1;
        beatQ <= 2'd0;
      end else if (validQ && outReady[o]) begin
        if (finalBeat) validQ <= 1'b0;
        else beatQ <= beatQ + 2'd1;
      end
    end

    assign outValid[o] = validQ;
    assign outData[o] = beatData;
    assign outLast[o] = lastQ && finalBeat && validQ;
  end

endmodule

// File: rtl/worm_node_ctrl.sv
module worm_node_ctrl
  import wnc_pkg::*;
#(
  parameter int FLIT_W = 32,
  parameter int COORD_W = 4,
  localparam int HDR_W = 2 * COORD_W
) (
  input  logic clk,
  input  logic rst,
  input  logic [COORD_W-1:0] nodeX,
  input  logic [COORD_W-1:0] nodeY,
  input  logic [1:0] chanMode,
  input  logic [NUM_PORTS-1:0] inValid,
  input  logic [NUM_PORTS-1:0][FLIT_W-1:0] inData,
  input  logic [NUM_PORTS-1:0] inLast,
  output logic [NUM_PORTS-1:0] inReady,
  output logic [NUM_PORTS-1:0] outValid,
  output logic [NUM_PORTS-1:0][FLIT_W-1:0] outData,
  output logic [NUM_PORTS-1:0] outLast,
  input  logic [NUM_PORTS-1:0] outReady,
  output logic [NUM_PORTS-1:0] chanBusy,
  output logic [2:0] freeLinks,
  output logic [4:0] freeSubCh
);

  dpCtl_t strobe;
  logic [NUM_PORTS-1:0] canLoad;
  logic [NUM_PORTS-1:0] reservedQ;
  logic [NUM_PORTS-1:0][HDR_W-1:0] inHdr;

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_hdr
    assign inHdr[i] = inData[i][HDR_W-1:0];
  end

  worm_node_ctl #(.COORD_W(COORD_W)) u_ctl (
    .clk(clk),
    .rst(rst),
    .nodeX(nodeX),
    .nodeY(nodeY),
    .chanMode(chanMode),
    .inValid(inValid),
    .inLast(inLast),
    .inHdr(inHdr),
    .canLoad(canLoad),
    .outValidQ(outValid),
    .inReady(inReady),
    .strobe(strobe),
    .reservedQ(reservedQ),
    .chanBusy(chanBusy),
    .freeLinks(freeLinks),
    .freeSubCh(freeSubCh)
  );

  worm_node_dp #(.FLIT_W(FLIT_W)) u_dp (
    .clk(clk),
    .rst(rst),
    .chanMode(chanMode),
    .strobe(strobe),
    .inData(inData),
    .inLast(inLast),
    .outReady(outReady),
    .canLoad(canLoad),
    .outValid(outValid),
    .outData(outData),
    .outLast(outLast)
  );

endmodule

// File: rtl/worm_node_ctrl_chk.sv
module worm_node_ctrl_chk
  import wnc_pkg::*;
#(
  parameter int FLIT_W = 32,
  localparam int HALF = FLIT_W / 2
) (
  input logic clk,
  input logic rst,
  input logic [1:0] chanMode,
  input logic [NUM_PORTS-1:0] outValid,
  input logic [NUM_PORTS-1:0] outReady,
  input logic [NUM_PORTS-1:0][FLIT_W-1:0] outData,
  input logic [NUM_PORTS-1:0] outLast,
  input logic [NUM_PORTS-1:0] reservedQ,
  input logic [NUM_PORTS-1:0] chanBusy,
  input dpCtl_t strobe
);

  for (genvar o = 0; o < NUM_PORTS; o++) begin : g_chk
    // R4: a stalled beat is held unchanged
    a_r4_stall_hold: assert property (@(posedge clk) disable iff (rst)
      (outValid[o] && !outReady[o]) |=>
        (outValid[o] && $stable(outData[o]) && $stable(outLast[o])));

    // R6: the tail mark only rides on a valid beat
    a_r6_last_valid: assert property (@(posedge clk) disable iff (rst)
      outLast[o] |-> outValid[o]);

    // R6: half-width beats keep the upper lanes at zero
    a_r6_half_upper_zero: assert property (@(posedge clk) disable iff (rst)
      (outValid[o] && chanMode == 2'b01) |-> (outData[o][FLIT_W-1:HALF] == '0));

    // R3: the datapath only loads an output that is reserved for a worm
    a_r3_load_reserved: assert property (@(posedge clk) disable iff (rst)
      strobe.load[o] |-> reservedQ[o]);

    // R7: a reservation is seen by the sampler one cycle later
    a_r7_busy_follows: assert property (@(posedge clk) disable iff (rst)
      reservedQ[o] |=> chanBusy[o]);

    // R7: an idle output reads as free one cycle later
    a_r7_idle_clears: assert property (@(posedge clk) disable iff (rst)
      (!reservedQ[o] && !outValid[o]) |=> !chanBusy[o]);
  end

endmodule

bind worm_node_ctrl worm_node_ctrl_chk #(.FLIT_W(FLIT_W)) u_chk (
  .clk(clk),
  .rst(rst),
  .chanMode(chanMode),
  .outValid(outValid),
  .outReady(outReady),
  .outData(outData),
  .outLast(outLast),
  .reservedQ(reservedQ),
  .chanBusy(chanBusy),
  .strobe(strobe)
);

// File: tb/tb_worm_node_ctrl.sv
`timescale 1ns/1ps
module tb_worm_node_ctrl;
  localparam int NP = 5;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] nodeX = 4'd5;
  logic [3:0] nodeY = 4'd5;
  logic [1:0] chanMode = 2'b00;
  logic [NP-1:0] inValid = '0;
  logic [NP-1:0] inLast = '0;
  logic [NP-1:0][W-1:0] inData = '0;
  logic [NP-1:0] inReady;
  logic [NP-1:0] outValid;
  logic [NP-1:0][W-1:0] outData;
  logic [NP-1:0] outLast;
  logic [NP-1:0] outReady = '1;
  logic [NP-1:0] chanBusy;
  logic [2:0] freeLinks;
  logic [4:0] freeSubCh;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit bpOn = 0;
  string curTag = "R1";
  logic [32:0] expQ [NP][$];
  int order[$];

  always #2.5 clk = ~clk;

  worm_node_ctrl dut (
    .clk(clk), .rst(rst), .nodeX(nodeX), .nodeY(nodeY), .chanMode(chanMode),
    .inValid(inValid), .inData(inData), .inLast(inLast), .inReady(inReady),
    .outValid(outValid), .outData(outData), .outLast(outLast), .outReady(outReady),
    .chanBusy(chanBusy), .freeLinks(freeLinks), .freeSubCh(freeSubCh)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int expectPort(input logic [3:0] dx, input logic [3:0] dy);
    if (dx > nodeX) return 0;
    if (dx < nodeX) return 1;
    if (dy > nodeY) return 2;
    if (dy < nodeY) return 3;
    return 4;
  endfunction

  // Driver: pushes each flit into the scoreboard as its input handshake completes.
  task automatic sendWorm(input int src, input logic [3:0] dx, input logic [3:0] dy,
                          input int nBody, input int pause);
    int port;
    port = expectPort(dx, dy);
    for (int k = 0; k <= nBody; k++) begin
      logic [31:0] d;
      logic l;
      l = (k == nBody);
      if (k == 0) d = {8'hC0 + 8'(src), 16'(nBody), dx, dy};
      else d = {8'(src), 8'(k), 16'h5A00 ^ 16'(k * 37)};
      if (l && k > 0 && pause > 0) begin
        @(posedge clk); #1;
        inValid[src] = 1'b0;
        repeat (pause) @(posedge clk);
      end
      @(posedge clk); #1;
      inValid[src] = 1'b1;
      inData[src] = d;
      inLast[src] = l;
      @(negedge clk);
      while (!inReady[src]) @(negedge clk);
      expQ[port].push_back({l, d});
      if (k == 0) order.push_back(src);
    end
    @(posedge clk); #1;
    inValid[src] = 1'b0;
    inLast[src] = 1'b0;
  endtask

  task automatic drain();
    int guard;
    guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while ((outValid != '0 || expQ[0].size() + expQ[1].size() + expQ[2].size()
               + expQ[3].size() + expQ[4].size() != 0) && guard < 2000);
    repeat (4) @(negedge clk);
    for (int o = 0; o < NP; o++)
      check(expQ[o].size() == 0, curTag, "flits never delivered", 64'(expQ[o].size()), 0);
  endtask

  task automatic doReset();
    @(posedge clk); #1 rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  // Output backpressure generator
  initial begin
    forever begin
      @(posedge clk); #1;
      if (bpOn) outReady = 5'($urandom);
      else outReady = '1;
    end
  end

  // Monitor: reassembles beats per output and compares with the scoreboard.
  initial begin
    logic [31:0] asmb [NP];
    int beat [NP];
    int nb;
    int sw;
    logic [31:0] slice;
    logic [32:0] exp;
    for (int o = 0; o < NP; o++) begin asmb[o] = '0; beat[o] = 0; end
    forever begin
      @(negedge clk);
      if (rst) begin
        for (int o = 0; o < NP; o++) begin asmb[o] = '0; beat[o] = 0; end
      end else begin
        nb = (chanMode == 2'b00) ? 1 : (chanMode == 2'b01) ? 2 : 4;
        sw = W / nb;
        for (int o = 0; o < NP; o++) begin
          if (outValid[o] && outReady[o]) begin
            if (nb == 1) begin
              asmb[o] = outData[o];
            end else begin
              slice = outData[o] & ((32'd1 << sw) - 32'd1);
              if ((outData[o] >> sw) != 0) begin
                check(0, "R6", "upper lanes not zero", 64'(outData[o]), 64'(slice));
              end
              asmb[o] = asmb[o] | (slice << (sw * beat[o]));
            end
            if (beat[o] == nb - 1) begin
              if (expQ[o].size() == 0) begin
                check(0, curTag, $sformatf("unexpected flit on port %0d", o),
                      64'({outLast[o], asmb[o]}), 0);
              end else begin
                exp = expQ[o].pop_front();
                check({outLast[o], asmb[o]} == exp, curTag,
                      $sformatf("flit on port %0d", o), 64'({outLast[o], asmb[o]}), 64'(exp));
              end
              beat[o] = 0;
              asmb[o] = '0;
            end else begin
              check(!outLast[o], "R6", "tail mark before final beat", 64'(outLast[o]), 0);
              beat[o]++;
            end
          end
        end
      end
    end
  end

  initial begin
    #800000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog R4 actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(outValid == '0, "R1", "outValid after reset", 64'(outValid), 0);
    check(inReady == '0, "R1", "inReady after reset", 64'(inReady), 0);
    check(chanBusy == '0, "R1", "chanBusy after reset", 64'(chanBusy), 0);
    check(freeLinks == 3'd4, "R1", "freeLinks after reset", 64'(freeLinks), 4);

    // R2: one worm toward every direction, then an X-first case
    curTag = "R2";
    fork
      sendWorm(4, 4'd7, 4'd5, 2, 0);
      sendWorm(0, 4'd2, 4'd5, 1, 0);
      sendWorm(1, 4'd5, 4'd9, 3, 0);
      sendWorm(2, 4'd5, 4'd1, 0, 0);
      sendWorm(3, 4'd5, 4'd5, 2, 0);
    join
    sendWorm(0, 4'd8, 4'd1, 1, 0);
    sendWorm(3, 4'd3, 4'd12, 1, 0);
    drain();

    // R7, R8, R3: status sampling and output locking during a paused worm
    curTag = "R3";
    fork
      sendWorm(4, 4'd7, 4'd5, 2, 14);
      begin
        @(negedge clk);
        while (!inReady[4]) @(negedge clk);
        check(chanBusy[0] == 1'b0, "R7", "busy one cycle late", 64'(chanBusy[0]), 0);
        @(negedge clk);
        check(chanBusy[0] == 1'b1, "R7", "busy after grant", 64'(chanBusy[0]), 1);
        check(freeLinks == 3'd3, "R8", "freeLinks with one busy", 64'(freeLinks), 3);
        check(freeSubCh == 5'd3, "R8", "freeSubCh full width", 64'(freeSubCh), 3);
      end
      begin
        repeat (8) @(posedge clk);
        fork
          sendWorm(2, 4'd9, 4'd5, 1, 0);
          begin
            repeat (3) @(negedge clk);
            check(inReady[2] == 1'b0, "R3", "second worm stalled on locked port",
                  64'(inReady[2]), 0);
            check(outValid[0] == 1'b0, "R3", "no foreign flit on locked port",
                  64'(outValid[0]), 0);
          end
        join
      end
    join
    drain();
    check(chanBusy == '0, "R7", "busy cleared after tail", 64'(chanBusy), 0);
    check(freeLinks == 3'd4, "R8", "freeLinks idle", 64'(freeLinks), 4);

    // R8: sub-channel counts in the narrower settings
    chanMode = 2'b01;
    @(negedge clk);
    check(freeSubCh == 5'd8, "R8", "freeSubCh idle halves", 64'(freeSubCh), 8);
    fork
      sendWorm(1, 4'd5, 4'd8, 1, 12);
      begin
        repeat (8) @(negedge clk);
        check(freeSubCh == 5'd6, "R8", "freeSubCh halves one busy", 64'(freeSubCh), 6);
      end
    join
    drain();
    chanMode = 2'b10;
    @(negedge clk);
    check(freeSubCh == 5'd16, "R8", "freeSubCh idle quarters", 64'(freeSubCh), 16);

    // R6: serialized transfer, half and quarter width, with contention
    curTag = "R6";
    chanMode = 2'b01;
    bpOn = 1;
    fork
      sendWorm(0, 4'd9, 4'd9, 3, 0);
      sendWorm(2, 4'd6, 4'd0, 2, 0);
      sendWorm(3, 4'd5, 4'd3, 1, 0);
    join
    drain();
    bpOn = 0;
    chanMode = 2'b10;
    fork
      sendWorm(4, 4'd0, 4'd5, 2, 0);
      sendWorm(1, 4'd1, 4'd7, 3, 0);
      sendWorm(2, 4'd5, 4'd5, 0, 0);
    join
    drain();

    // R4: full width, random backpressure, several worms sharing outputs
    curTag = "R4";
    chanMode = 2'b00;
    bpOn = 1;
    fork
      sendWorm(0, 4'd9, 4'd2, 4, 0);
      sendWorm(1, 4'd7, 4'd7, 3, 0);
      sendWorm(2, 4'd5, 4'd14, 5, 0);
      sendWorm(3, 4'd6, 4'd5, 2, 0);
      sendWorm(4, 4'd5, 4'd10, 3, 0);
    join
    drain();
    bpOn = 0;

    // R5: round-robin order on one output
    curTag = "R5";
    doReset();
    order.delete();
    fork
      sendWorm(1, 4'd2, 4'd5, 2, 0);
      sendWorm(3, 4'd2, 4'd5, 2, 0);
    join
    drain();
    fork
      sendWorm(2, 4'd1, 4'd5, 1, 0);
      sendWorm(4, 4'd1, 4'd5, 1, 0);
    join
    drain();
    check(order.size() == 4, "R5", "header count", 64'(order.size()), 4);
    if (order.size() == 4) begin
      check(order[0] == 1, "R5", "first winner after reset", 64'(order[0]), 1);
      check(order[1] == 3, "R5", "second grant", 64'(order[1]), 3);
      check(order[2] == 4, "R5", "rotation past last winner", 64'(order[2]), 4);
      check(order[3] == 2, "R5", "fourth grant", 64'(order[3]), 2);
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule